// File: doc/BRIEF.md
# Cascaded Dual-Channel Converter Update Master

This block is the host-side serial master for a set of dual-channel 12-bit converters. The converters are either cascaded, each data output feeding the next data input, or they share one data line. One request on a parallel interface carries a channel A code and a channel B code for each of `NUM_DEV` devices, plus a mode bit. The master turns the request into a single frame of `2*CODE_W` bits per device and shifts it out MSB first, on a serial clock that idles low. Data changes on the falling edge so that the devices can sample it on the rising edge. It then commits every converter at once and pulses `done`.

Two commit styles are supported. In three-wire mode the load strobe is held low, so raising chip select after the last bit commits all latches. In four-wire mode the strobe stays high through the frame. After chip select rises and a set-up interval passes, the strobe is driven low for a timed pulse. While the frame shifts, the bits returned at the far end of the chain are sampled on each rising serial clock. They are regrouped into the previous contents of every device and returned as read-back codes.

Serial clock half-period, select-to-clock set-up and load pulse width are parameters counted in system clock cycles. The serial rate can therefore be derated to suit the pull-up loading of a long chain.

Top module: `dcm_chain_master`

## Requirements
- R1: After reset and between transfers `cs_n` is 1, `sclk` is 0, `busy` and `done` are 0. `load_n` is 1 after reset.
- R2: A transfer sends `2*CODE_W*NUM_DEV` bits. Device `NUM_DEV-1` (farthest from the master) goes first and device 0 (nearest) goes last. Within each device the channel B code precedes the channel A code, each MSB first. Device `i` takes slice `i*CODE_W +: CODE_W` of `req_code_a` and `req_code_b`.
- R3: Each high phase and each low phase of `sclk` lasts `DIV_HALF` system cycles. `sdo` changes only while `sclk` falls or is low, never during a high phase.
- R4: The first `sclk` rise follows the fall of `cs_n` by `SETUP_CYC` cycles. `cs_n` rises `DIV_HALF` cycles after the last `sclk` fall.
- R5: Each transfer contains exactly `2*CODE_W*NUM_DEV` rising edges of `sclk`, all with `cs_n` low.
- R6: With `req_four_wire`=0, `load_n` goes low when the request is taken and stays low afterwards. `done` is high in the cycle in which `cs_n` returns high, and the devices commit on that rise.
- R7: With `req_four_wire`=1, `load_n` is 1 while `cs_n` is low. It falls `SETUP_CYC` cycles after `cs_n` rises and stays low for `LOAD_CYC` cycles. `done` is high in the cycle in which `load_n` returns high. No device commits before the strobe falls.
- R8: `sdi` is sampled at every `sclk` rise. At `done`, `rb_code_b` and `rb_code_a` slice `i` hold the codes device `i` held before the transfer. They stay unchanged until the next request is taken.
- R9: `done` is high for exactly one cycle per transfer. `busy` is high from the cycle after a request is taken until `done`.
- R10: A `req_valid` pulse while `busy` is 1 is ignored. It starts no new frame and does not change the codes being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer; taken only when idle |
| req_four_wire | input | 1 | 1: commit with a timed load pulse; 0: commit on chip-select rise |
| req_code_a | input | NUM_DEV*CODE_W | Channel A codes, device i in slice i |
| req_code_b | input | NUM_DEV*CODE_W | Channel B codes, device i in slice i |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rb_code_a | output | NUM_DEV*CODE_W | Previous channel A codes read back from the chain end |
| rb_code_b | output | NUM_DEV*CODE_W | Previous channel B codes read back from the chain end |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the first device |
| sdi | input | 1 | Serial data returned from the last device |
| cs_n | output | 1 | Chip select, active low |
| load_n | output | 1 | Load strobe, active low |

## Verification
The bench drives a behavioural two-device cascade. It applies codes of all ones and all zeros on opposite channels and devices, which exposes any swap between channels or between devices. Walking single-bit codes expose bit reversal or an off-by-one shift. Alternating patterns and mixed values check that neighbouring bits stay apart. Three-wire and four-wire requests alternate, so the strobe's transitions between modes and the commit point of each mode are both exercised. Each transfer's read-back is compared with the codes of the previous one, which tests the regrouping of the returned stream. A request raised during a busy frame checks that it is ignored.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP,
        ST_PULSE
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dcm_frame_map.sv
module dcm_frame_map #(
    parameter int NUM_DEV = 2,
    parameter int CODE_W  = 12
) (
    input  logic [NUM_DEV*CODE_W-1:0]   code_a,
    input  logic [NUM_DEV*CODE_W-1:0]   code_b,
    output logic [2*NUM_DEV*CODE_W-1:0] frame,
    input  logic [2*NUM_DEV*CODE_W-1:0] rx_word,
    output logic [NUM_DEV*CODE_W-1:0]   rb_a,
    output logic [NUM_DEV*CODE_W-1:0]   rb_b
);

    // Device i occupies bits [2*i*CODE_W +: 2*CODE_W]; B is the upper half.
    // The frame leaves MSB first, so the highest device index goes first.
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign frame[(2*i+1)*CODE_W +: CODE_W] = code_b[i*CODE_W +: CODE_W];
        assign frame[(2*i)*CODE_W   +: CODE_W] = code_a[i*CODE_W +: CODE_W];
        assign rb_b[i*CODE_W +: CODE_W]        = rx_word[(2*i+1)*CODE_W +: CODE_W];
        assign rb_a[i*CODE_W +: CODE_W]        = rx_word[(2*i)*CODE_W   +: CODE_W];
    end

endmodule

// File: rtl/dcm_shreg.sv
module dcm_shreg #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift_en,
    input  logic               sample_en,
    input  logic               sdi,
    output logic               sdo,
    output logic [FRAME_W-1:0] rx_word
);

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
    } shreg_t;

    shreg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_en) begin
            r_d.tx = frame_in;
        end else if (shift_en) begin
            r_d.tx = {r_q.tx[FRAME_W-2:0], 1'b0};
        end
        if (sample_en) begin
            r_d.rx = {r_q.rx[FRAME_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo     = r_q.tx[FRAME_W-1];
    assign rx_word = r_q.rx;

endmodule

// File: rtl/dcm_seq.sv
module dcm_seq
    import dcm_pkg::*;
#(
    parameter int FRAME_W   = 48,
    parameter int DIV_HALF  = 4,
    parameter int SETUP_CYC = 3,
    parameter int LOAD_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_four_wire,
    output logic load_en,
    output logic shift_en,
    output logic sample_en,
    output logic busy,
    output logic done,
    output logic sclk,
    output logic cs_n,
    output logic load_n
);

    localparam int MAX_CNT = max3(DIV_HALF, SETUP_CYC, LOAD_CYC);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int BIT_W   = $clog2(FRAME_W);

    localparam logic [CNT_W-1:0] DIV_RELOAD   = CNT_W'(DIV_HALF - 1);
    localparam logic [CNT_W-1:0] SETUP_RELOAD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_RELOAD  = CNT_W'(LOAD_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT     = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic             four;
        logic             sclk;
        logic             cs_n;
        logic             load_n;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic cnt_zero;

    assign cnt_zero = (s_q.cnt == '0);

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        load_en   = 1'b0;
        shift_en  = 1'b0;
        sample_en = 1'b0;
        if (!cnt_zero) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.cnt = '0;
                if (req_valid) begin
                    load_en    = 1'b1;
                    s_d.st     = ST_LEAD;
                    s_d.cs_n   = 1'b0;
                    s_d.four   = req_four_wire;
                    s_d.load_n = req_four_wire;
                    s_d.cnt    = SETUP_RELOAD;
                    s_d.bits   = LAST_BIT;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (cnt_zero) begin
                    s_d.st    = ST_HIGH;
                    s_d.sclk  = 1'b1;
                    s_d.cnt   = DIV_RELOAD;
                    sample_en = 1'b1;
                end
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    s_d.sclk = 1'b0;
                    s_d.cnt  = DIV_RELOAD;
                    if (s_q.bits == '0) begin
                        s_d.st = ST_TAIL;
                    end else begin
                        s_d.st   = ST_LOW;
                        s_d.bits = s_q.bits - 1'b1;
                        shift_en = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (cnt_zero) begin
                    s_d.cs_n = 1'b1;
                    if (s_q.four) begin
                        s_d.st  = ST_GAP;
                        s_d.cnt = SETUP_RELOAD;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    s_d.st     = ST_PULSE;
                    s_d.load_n = 1'b0;
                    s_d.cnt    = LOAD_RELOAD;
                end
            end
            ST_PULSE: begin
                if (cnt_zero) begin
                    s_d.st     = ST_IDLE;
                    s_d.load_n = 1'b1;
                    s_d.done   = 1'b1;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.cnt    <= '0;
            s_q.bits   <= '0;
            s_q.four   <= 1'b0;
            s_q.sclk   <= 1'b0;
            s_q.cs_n   <= 1'b1;
            s_q.load_n <= 1'b1;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.st != ST_IDLE);
    assign done   = s_q.done;
    assign sclk   = s_q.sclk;
    assign cs_n   = s_q.cs_n;
    assign load_n = s_q.load_n;

endmodule

// File: rtl/dcm_chain_master.sv
module dcm_chain_master #(
    parameter int NUM_DEV   = 2,
    parameter int CODE_W    = 12,
    parameter int DIV_HALF  = 4,
    parameter int SETUP_CYC = 3,
    parameter int LOAD_CYC  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_four_wire,
    input  logic [NUM_DEV*CODE_W-1:0] req_code_a,
    input  logic [NUM_DEV*CODE_W-1:0] req_code_b,
    output logic                      busy,
    output logic                      done,
    output logic [NUM_DEV*CODE_W-1:0] rb_code_a,
    output logic [NUM_DEV*CODE_W-1:0] rb_code_b,
    output logic                      sclk,
    output logic                      sdo,
    input  logic                      sdi,
    output logic                      cs_n,
    output logic                      load_n
);

    localparam int FRAME_W = 2 * NUM_DEV * CODE_W;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] rx_word;
    logic               load_en;
    logic               shift_en;
    logic               sample_en;

    dcm_frame_map #(
        .NUM_DEV (NUM_DEV),
        .CODE_W  (CODE_W)
    ) i_map (
        .code_a  (req_code_a),
        .code_b  (req_code_b),
        .frame   (frame),
        .rx_word (rx_word),
        .rb_a    (rb_code_a),
        .rb_b    (rb_code_b)
    );

    dcm_shreg #(
        .FRAME_W (FRAME_W)
    ) i_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .frame_in  (frame),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_word   (rx_word)
    );

    dcm_seq #(
        .FRAME_W   (FRAME_W),
        .DIV_HALF  (DIV_HALF),
        .SETUP_CYC (SETUP_CYC),
        .LOAD_CYC  (LOAD_CYC)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_four_wire (req_four_wire),
        .load_en       (load_en),
        .shift_en      (shift_en),
        .sample_en     (sample_en),
        .busy          (busy),
        .done          (done),
        .sclk          (sclk),
        .cs_n          (cs_n),
        .load_n        (load_n)
    );

endmodule

// File: rtl/dcm_chain_master_chk.sv
module dcm_chain_master_chk #(
    parameter int NUM_DEV = 2,
    parameter int CODE_W  = 12
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdo,
    input logic cs_n,
    input logic load_n
);

    localparam int FRAME_W = 2 * NUM_DEV * CODE_W;

    logic        sclk_p;
    logic        cs_n_p;
    logic [15:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            cs_n_p   <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sclk_p <= sclk;
            cs_n_p <= cs_n;
            if (cs_n_p && !cs_n) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_p) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R1: idle lines
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    // R3: data held through every high phase
    a_r3_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sclk_p) |-> $stable(sdo));

    // R5: clock only inside a frame, frame length exact
    a_r5_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 16'(FRAME_W)));

    // R6: three-wire completion coincides with deselect
    a_r6_select_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && !load_n) |-> done);

    // R7: four-wire completion coincides with end of strobe
    a_r7_strobe_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_n) && cs_n) |-> done);

    // R9: single-cycle completion
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a frame starts only from an accepted idle request
    a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid && !busy));

endmodule

bind dcm_chain_master dcm_chain_master_chk #(
    .NUM_DEV (NUM_DEV),
    .CODE_W  (CODE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .sclk      (sclk),
    .sdo       (sdo),
    .cs_n      (cs_n),
    .load_n    (load_n)
);

// File: tb/test_dcm_chain_master.sv
`timescale 1ns/1ps
module test_dcm_chain_master;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 2;
    localparam int CODE_W     = 12;
    localparam int DIV_HALF   = 3;
    localparam int SETUP_CYC  = 4;
    localparam int LOAD_CYC   = 5;
    localparam int DEV_W      = 2 * CODE_W;
    localparam int FRAME_W    = NUM_DEV * DEV_W;
    localparam int NVEC       = 6;

    // entry: {four_wire, dev1 B, dev1 A, dev0 B, dev0 A}
    localparam logic [48:0] VECS [NVEC] = '{
        {1'b0, 12'hFFF, 12'h000, 12'h800, 12'h001},
        {1'b1, 12'hA5A, 12'h5A5, 12'h123, 12'hFED},
        {1'b0, 12'h000, 12'hFFF, 12'h7FF, 12'h800},
        {1'b1, 12'h001, 12'h002, 12'h004, 12'h008},
        {1'b1, 12'hC3C, 12'h3C3, 12'h0F0, 12'hF0F},
        {1'b0, 12'h456, 12'h789, 12'hABC, 12'hDEF}
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      req_valid = 1'b0;
    logic                      req_four_wire = 1'b0;
    logic [NUM_DEV*CODE_W-1:0] req_code_a = '0;
    logic [NUM_DEV*CODE_W-1:0] req_code_b = '0;
    logic                      busy, done, sclk, sdo, sdi, cs_n, load_n;
    logic [NUM_DEV*CODE_W-1:0] rb_code_a, rb_code_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcm_chain_master #(
        .NUM_DEV   (NUM_DEV),
        .CODE_W    (CODE_W),
        .DIV_HALF  (DIV_HALF),
        .SETUP_CYC (SETUP_CYC),
        .LOAD_CYC  (LOAD_CYC)
    ) i_dcm_chain_master (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_four_wire (req_four_wire),
        .req_code_a    (req_code_a),
        .req_code_b    (req_code_b),
        .busy          (busy),
        .done          (done),
        .rb_code_a     (rb_code_a),
        .rb_code_b     (rb_code_b),
        .sclk          (sclk),
        .sdo           (sdo),
        .sdi           (sdi),
        .cs_n          (cs_n),
        .load_n        (load_n)
    );

    // Behavioural cascade: device 0 is fed by the master.
    logic [DEV_W-1:0] dev_sr  [NUM_DEV] = '{default: '0};
    logic             dev_out [NUM_DEV] = '{default: 1'b0};
    logic [DEV_W-1:0] dev_lat [NUM_DEV] = '{default: '0};

    always @(posedge sclk) begin
        if (!cs_n) begin
            for (int i = 0; i < NUM_DEV; i++) begin
                dev_sr[i] <= {dev_sr[i][DEV_W-2:0], (i == 0) ? sdo : dev_out[i-1]};
            end
        end
    end

    always @(negedge sclk or negedge cs_n) begin
        for (int i = 0; i < NUM_DEV; i++) dev_out[i] <= dev_sr[i][DEV_W-1];
    end

    always @(posedge clk) begin
        if (cs_n && !load_n) begin
            for (int i = 0; i < NUM_DEV; i++) dev_lat[i] <= dev_sr[i];
        end
    end

    assign sdi = dev_out[NUM_DEV-1];

    // Line monitor, sampled at the falling system clock edge.
    int cyc = 0, rises = 0, cs_falls = 0, done_hi = 0, done_wide = 0;
    int bad_per = 0, sdo_bad = 0;
    int t_cs_fall = 0, t_first = 0, t_last_rise = 0, t_last_fall = 0;
    int t_cs_rise = 0, t_load_fall = 0, t_load_rise = 0, t_done = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_load = 1'b1, p_done = 1'b0, p_sdo = 1'b0;
    logic [DEV_W-1:0] snap [NUM_DEV];
    bit snap_taken = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !cs_n) begin t_cs_fall = cyc; rises = 0; cs_falls++; end
            if (!p_sclk && sclk) begin
                if (rises == 0) t_first = cyc;
                else if (cyc - t_last_rise != 2 * DIV_HALF) bad_per++;
                t_last_rise = cyc;
                rises++;
            end
            if (p_sclk && !sclk) t_last_fall = cyc;
            if (p_sclk && sclk && (sdo !== p_sdo)) sdo_bad++;
            if (!p_cs && cs_n) t_cs_rise = cyc;
            if (p_load && !load_n) t_load_fall = cyc;
            if (!p_load && load_n) t_load_rise = cyc;
            if (cs_n && load_n && busy) begin
                for (int i = 0; i < NUM_DEV; i++) snap[i] = dev_lat[i];
                snap_taken = 1'b1;
            end
            if (done) begin
                done_hi++;
                t_done = cyc;
                if (p_done) done_wide++;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_load = load_n; p_done = done; p_sdo = sdo;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // One full transfer; codes are {dev1, dev0}, old_* are the expected read-back.
    task automatic do_xfer(input logic four, input logic [23:0] cb, input logic [23:0] ca,
                           input logic [23:0] ob, input logic [23:0] oa);
        int done_before;
        done_before = done_hi;
        snap_taken  = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_four_wire = four; req_code_b = cb; req_code_a = ca;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
        while (done !== 1'b1) @(negedge clk);
        #1;
        check(t_first - t_cs_fall == SETUP_CYC, "R4", "select to first rise",
              32'(t_first - t_cs_fall), 32'(SETUP_CYC));
        check(t_cs_rise - t_last_fall == DIV_HALF, "R4", "last fall to deselect",
              32'(t_cs_rise - t_last_fall), 32'(DIV_HALF));
        check(rises == FRAME_W, "R5", "rising edges", 32'(rises), 32'(FRAME_W));
        check(bad_per == 0, "R3", "clock period errors", 32'(bad_per), 32'd0);
        check(sdo_bad == 0, "R3", "data change in high phase", 32'(sdo_bad), 32'd0);
        check(rb_code_b == ob, "R8", "read-back B", 32'(rb_code_b), 32'(ob));
        check(rb_code_a == oa, "R8", "read-back A", 32'(rb_code_a), 32'(oa));
        if (four) begin
            check(t_load_fall - t_cs_rise == SETUP_CYC, "R7", "deselect to strobe",
                  32'(t_load_fall - t_cs_rise), 32'(SETUP_CYC));
            check(t_load_rise - t_load_fall == LOAD_CYC, "R7", "strobe width",
                  32'(t_load_rise - t_load_fall), 32'(LOAD_CYC));
            check(t_done == t_load_rise, "R7", "done at strobe end",
                  32'(t_done), 32'(t_load_rise));
            check(snap_taken && snap[1] == {ob[23:12], oa[23:12]} && snap[0] == {ob[11:0], oa[11:0]},
                  "R7", "no commit before strobe", 32'(snap[0]), 32'({ob[11:0], oa[11:0]}));
        end else begin
            check(t_done == t_cs_rise, "R6", "done at deselect", 32'(t_done), 32'(t_cs_rise));
            check(load_n === 1'b0, "R6", "strobe held low", 32'(load_n), 32'd0);
        end
        repeat (3) @(negedge clk);
        #1;
        check(done_hi == done_before + 1 && done_wide == 0, "R9", "one-cycle done",
              32'(done_hi - done_before), 32'd1);
        check(dev_lat[1] == {cb[23:12], ca[23:12]}, "R2", "far device latch",
              32'(dev_lat[1]), 32'({cb[23:12], ca[23:12]}));
        check(dev_lat[0] == {cb[11:0], ca[11:0]}, "R2", "near device latch",
              32'(dev_lat[0]), 32'({cb[11:0], ca[11:0]}));
        check(rb_code_b == ob && rb_code_a == oa, "R8", "read-back held",
              32'(rb_code_a), 32'(oa));
        check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1", "idle lines",
              32'({cs_n, sclk, busy}), 32'b100);
        check(load_n === four, "R6", "strobe level after transfer", 32'(load_n), 32'(four));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [23:0] ob, oa, xb, xa;
        int falls_before;
        repeat (5) @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0 && load_n === 1'b1, "R1", "lines in reset",
              32'({cs_n, sclk, load_n}), 32'b101);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && cs_n === 1'b1 && load_n === 1'b1,
              "R1", "state after reset", 32'({busy, done, cs_n, load_n}), 32'b0011);

        ob = '0; oa = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] cb, ca;
            cb = {VECS[v][47:36], VECS[v][23:12]};
            ca = {VECS[v][35:24], VECS[v][11:0]};
            do_xfer(VECS[v][48], cb, ca, ob, oa);
            ob = cb; oa = ca;
        end

        // R10: second request during a busy frame must be ignored
        xb = 24'h3E1_1C7; xa = 24'h0AA_F55;
        falls_before = cs_falls;
        @(negedge clk);
        req_valid = 1'b1; req_four_wire = 1'b0; req_code_b = xb; req_code_a = xa;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(busy === 1'b1, "R10", "still busy mid-frame", 32'(busy), 32'd1);
        req_valid = 1'b1; req_four_wire = 1'b1; req_code_b = 24'hFFF_FFF; req_code_a = 24'hFFF_FFF;
        @(negedge clk);
        req_valid = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        #1;
        check(rb_code_b == ob && rb_code_a == oa, "R8", "read-back after ignore test",
              32'(rb_code_b), 32'(ob));
        repeat (3) @(negedge clk);
        #1;
        check(cs_falls == falls_before + 1, "R10", "frames started", 32'(cs_falls - falls_before), 32'd1);
        check(dev_lat[1] == {xb[23:12], xa[23:12]} && dev_lat[0] == {xb[11:0], xa[11:0]},
              "R10", "codes unchanged by ignored request", 32'(dev_lat[0]), 32'({xb[11:0], xa[11:0]}));
        check(load_n === 1'b0, "R10", "mode unchanged by ignored request", 32'(load_n), 32'd0);
        repeat (20) @(negedge clk);
        check(busy === 1'b0 && cs_n === 1'b1, "R10", "no extra frame", 32'({busy, cs_n}), 32'b01);
        finish_run();
    end

endmodule